// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block takes one exact, unpacked floating-point result and rounds it to a narrower target format. An arithmetic stage delivers the result as a sign, a signed unbiased exponent, a wide significand whose leading one always sits in the top bit, and three class flags (NaN, infinity, zero). The block returns the rounded value in the same unpacked style. The target-precision significand carries its leading one explicitly. The result has a signed unbiased exponent, and the output class flags are set when the value becomes special.

Normal results need no normalising shift, because the position of the leading one is fixed. For results below the smallest normal exponent, the significand is shifted right by a variable amount. Every bit shifted out is ORed into the sticky bit, and the exponent is clamped to the normal minimum. Rounding follows one of five modes. An increment that carries out of the significand is renormalised to 1.0 and the exponent is bumped. Only after that is the exponent checked for overflow. The result is held in one output register and appears one cycle after the input is accepted.

Top module: `fp_round_unit`

## Requirements
- R1: A result appears on the outputs, with `outValid` high, exactly one clock after `inValid` is high. `outValid` is low after reset and in every cycle that follows a cycle with `inValid` low.
- R2: The significand is split as follows. The kept bits are the top P = FRAC_W+1 bits of the input significand after any subnormal shift. The guard bit is the next bit below them. The sticky bit is the OR of all lower bits. When the guard and sticky bits are both zero, the kept bits and the exponent pass through unchanged in every mode.
- R3: Mode 0 rounds to nearest with ties to even. It increments when the dropped part is above half an ulp. It also increments when the dropped part is exactly half and the lowest kept bit is 1. Otherwise it truncates.
- R4: Mode 1 rounds to nearest with ties away. It increments whenever the dropped part is at least half an ulp.
- R5: Mode 2 (toward +inf) increments a positive value with any nonzero dropped part. Mode 3 (toward -inf) does the same for a negative value. Mode 4 (toward zero) never increments and never produces infinity from a finite input.
- R6: If an increment carries out of the P-bit significand, the output significand becomes 1 followed by zeros (value 1.0) and the exponent is one higher.
- R7: When the rounded exponent exceeds EMAX = 2^(EXP_W-1)-1, the result is either infinity or the largest finite value. Infinity sets `outInf` with exponent 0 and significand 0. The largest finite value has exponent EMAX and an all-ones significand. Infinity is chosen in modes 0 and 1, in mode 2 for a positive sign, and in mode 3 for a negative sign. Otherwise the largest finite value is chosen. Finite results always have an exponent in [EMIN, EMAX].
- R8: An input exponent below EMIN = 2-2^(EXP_W-1) shifts the significand right by EMIN minus that exponent before the split. Bits shifted out are ORed into the sticky bit. The output exponent is EMIN. The output significand top bit is 0, unless rounding carries the value up to the smallest normal.
- R9: When the rounded significand is zero, `outZero` is set with exponent 0, significand 0 and the input sign. A value far below the subnormal range therefore becomes zero, or the smallest subnormal (significand 1, exponent EMIN), depending on mode and sign.
- R10: A NaN, infinity or zero flag on the input bypasses rounding. The same single flag appears on the output with the input sign, and exponent and significand are 0. Priority is NaN over infinity over zero. At most one output flag is ever high.
- R11: The mode codes 5, 6 and 7 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input result is present this cycle |
| rndMode | input | 3 | Rounding mode code (0..4, 5..7 as 0) |
| inSign | input | 1 | Sign of the exact result |
| inExp | input | EXT_W | Signed unbiased exponent of the exact result |
| inSig | input | IN_W | Exact significand, leading one in the top bit |
| inNan | input | 1 | Input is NaN |
| inInf | input | 1 | Input is infinity |
| inZero | input | 1 | Input is zero |
| outValid | output | 1 | Rounded result is present |
| outSign | output | 1 | Result sign |
| outExp | output | EXT_W | Result signed unbiased exponent |
| outSig | output | FRAC_W+1 | Result significand, explicit leading bit |
| outNan | output | 1 | Result is NaN |
| outInf | output | 1 | Result is infinity |
| outZero | output | 1 | Result is zero |

## Verification
A wrong shift amount or a lost sticky contribution shows up on the very next output. It appears as a significand one ulp off, or as an exponent other than EMIN on a subnormal result. The bench targets exact ties, single sticky bits, and shifts well past the significand width. A missed late carry leaves an all-zero significand or a stale exponent. A wrong overflow decision flips between `outInf` and the all-ones largest value. Each of these is compared in the cycle after the stimulus, against a rational reference that compares the dropped remainder with half an ulp and does not use guard and sticky bits.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_NEAR_AWAY = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_ZERO      = 3'd4
  } rndMode_e;

  // Facts the datapath exposes to the decision logic
  typedef struct packed {
    logic sign;
    logic guardBit;
    logic stickyBit;
    logic lsbBit;
  } rndTap_t;

  // Strobes from the decision logic back to the datapath
  typedef struct packed {
    logic roundUp;
    logic ovfToInf;
  } rndCtl_t;

endpackage

// File: rtl/fp_round_ctrl.sv
module fp_round_ctrl
  import fp_round_pkg::*;
(
  input  logic [2:0] rndMode,
  input  rndTap_t    tap,
  output rndCtl_t    ctl
);

  logic anyLost;

  always_comb begin
    anyLost = tap.guardBit | tap.stickyBit;
    ctl     = '0;
    case (rndMode)
      RM_NEAR_AWAY: begin
        ctl.roundUp  = tap.guardBit;
        ctl.ovfToInf = 1'b1;
      end
      RM_UP: begin
        ctl.roundUp  = ~tap.sign & anyLost;
        ctl.ovfToInf = ~tap.sign;
      end
      RM_DOWN: begin
        ctl.roundUp  = tap.sign & anyLost;
        ctl.ovfToInf = tap.sign;
      end
      RM_ZERO: begin
        ctl.roundUp  = 1'b0;
        ctl.ovfToInf = 1'b0;
      end
      default: begin // nearest-even, also codes 5..7
        ctl.roundUp  = tap.guardBit & (tap.stickyBit | tap.lsbBit);
        ctl.ovfToInf = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fp_round_datapath.sv
module fp_round_datapath
  import fp_round_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int IN_W   = 24,
  parameter int EXT_W  = EXP_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              rndMode,
  input  logic                    inSign,
  input  logic signed [EXT_W-1:0] inExp,
  input  logic [IN_W-1:0]         inSig,
  input  logic                    inNan,
  input  logic                    inInf,
  input  logic                    inZero,
  input  rndCtl_t                 ctl,
  output rndTap_t                 tap,
  output logic                    outValid,
  output logic                    outSign,
  output logic signed [EXT_W-1:0] outExp,
  output logic [FRAC_W:0]         outSig,
  output logic                    outNan,
  output logic                    outInf,
  output logic                    outZero
);

  localparam int P    = FRAC_W + 1;
  localparam int EMIN = 2 - (1 << (EXP_W - 1));
  localparam int EMAX = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EXT_W:0] EMIN_X = (EXT_W + 1)'(EMIN);
  localparam logic signed [EXT_W:0] EMAX_X = (EXT_W + 1)'(EMAX);

  // Split stage
  logic signed [EXT_W:0] expIn;
  logic signed [EXT_W:0] expBase;
  logic                  belowMin;
  logic [EXT_W:0]        shAmt;
  logic [IN_W-1:0]       shifted;
  logic [IN_W-1:0]       lostMask;
  logic                  shiftSticky;
  logic [P-1:0]          kept;

  always_comb begin
    expIn       = {inExp[EXT_W-1], inExp};
    belowMin    = expIn < EMIN_X;
    shAmt       = belowMin ? (EMIN_X - expIn) : '0;
    expBase     = belowMin ? EMIN_X : expIn;
    shifted     = inSig >> shAmt;
    lostMask    = ~({IN_W{1'b1}} << shAmt);
    shiftSticky = |(inSig & lostMask);
    kept        = shifted[IN_W-1 -: P];
    tap.sign      = inSign;
    tap.guardBit  = shifted[IN_W-1-P];
    tap.stickyBit = (|shifted[IN_W-2-P:0]) | shiftSticky;
    tap.lsbBit    = kept[0];
  end

  // Increment, late carry, overflow and underflow stage
  logic [P:0]            sum;
  logic                  carryOut;
  logic [P-1:0]          sigR;
  logic signed [EXT_W:0] expR;
  logic                  ovf;
  logic                  allLost;
  logic                  nSign, nNan, nInf, nZero;
  logic signed [EXT_W-1:0] nExp;
  logic [P-1:0]          nSig;

  always_comb begin
    sum      = {1'b0, kept} + (P + 1)'(ctl.roundUp);
    carryOut = sum[P];
    sigR     = carryOut ? {1'b1, {(P-1){1'b0}}} : sum[P-1:0];
    expR     = expBase + (EXT_W + 1)'(carryOut);
    ovf      = expR > EMAX_X;
    allLost  = (sigR == '0);

    nSign = inSign;
    nNan  = 1'b0;
    nInf  = 1'b0;
    nZero = 1'b0;
    nExp  = '0;
    nSig  = '0;
    if (inNan) begin
      nNan = 1'b1;
    end else if (inInf) begin
      nInf = 1'b1;
    end else if (inZero) begin
      nZero = 1'b1;
    end else if (ovf) begin
      if (ctl.ovfToInf) begin
        nInf = 1'b1;
      end else begin
        nExp = EMAX_X[EXT_W-1:0];
        nSig = '1;
      end
    end else if (allLost) begin
      nZero = 1'b1;
    end else begin
      nExp = expR[EXT_W-1:0];
      nSig = sigR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSign  <= 1'b0;
      outExp   <= '0;
      outSig   <= '0;
      outNan   <= 1'b0;
      outInf   <= 1'b0;
      outZero  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outSign <= nSign;
        outExp  <= nExp;
        outSig  <= nSig;
        outNan  <= nNan;
        outInf  <= nInf;
        outZero <= nZero;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R1
  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN) (inValid && !inNan && !inInf && !inZero) |-> inSig[IN_W-1]); // R2
  AST_ZERO_NO_INF: assert property (@(posedge clk) disable iff (!rstN) (inValid && rndMode == RM_ZERO && !inNan && !inInf) |=> !outInf); // R5
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outNan && !outInf && !outZero) |-> ($signed(outExp) >= EMIN && $signed(outExp) <= EMAX)); // R7
  AST_SUBNORM_EXP: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outNan && !outInf && !outZero && !outSig[P-1]) |-> ($signed(outExp) == EMIN)); // R8
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) outValid |-> $onehot0({outNan, outInf, outZero})); // R10
  AST_NAN_PASS: assert property (@(posedge clk) disable iff (!rstN) (inValid && inNan) |=> (outNan && outSig == '0)); // R10

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int IN_W   = 24,
  parameter int EXT_W  = EXP_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              rndMode,
  input  logic                    inSign,
  input  logic signed [EXT_W-1:0] inExp,
  input  logic [IN_W-1:0]         inSig,
  input  logic                    inNan,
  input  logic                    inInf,
  input  logic                    inZero,
  output logic                    outValid,
  output logic                    outSign,
  output logic signed [EXT_W-1:0] outExp,
  output logic [FRAC_W:0]         outSig,
  output logic                    outNan,
  output logic                    outInf,
  output logic                    outZero
);

  rndTap_t tap;
  rndCtl_t ctl;

  fp_round_ctrl u_ctrl (
    .rndMode (rndMode),
    .tap     (tap),
    .ctl     (ctl)
  );

  fp_round_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .IN_W   (IN_W),
    .EXT_W  (EXT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rndMode  (rndMode),
    .inSign   (inSign),
    .inExp    (inExp),
    .inSig    (inSig),
    .inNan    (inNan),
    .inInf    (inInf),
    .inZero   (inZero),
    .ctl      (ctl),
    .tap      (tap),
    .outValid (outValid),
    .outSign  (outSign),
    .outExp   (outExp),
    .outSig   (outSig),
    .outNan   (outNan),
    .outInf   (outInf),
    .outZero  (outZero)
  );

endmodule

// File: tb/fp_round_unit_bench.sv
module fp_round_unit_bench;

  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int IN_W   = 24;
  localparam int EXT_W  = 7;
  localparam int P      = FRAC_W + 1;
  localparam int EMIN   = -14;
  localparam int EMAX   = 15;
  localparam int VEC_W  = 1 + EXT_W + P + 3;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic [2:0]              rndMode = 3'd0;
  logic                    inSign = 1'b0;
  logic signed [EXT_W-1:0] inExp = '0;
  logic [IN_W-1:0]         inSig = '0;
  logic                    inNan = 1'b0;
  logic                    inInf = 1'b0;
  logic                    inZero = 1'b0;
  logic                    outValid, outSign, outNan, outInf, outZero;
  logic signed [EXT_W-1:0] outExp;
  logic [FRAC_W:0]         outSig;

  int checks = 0;
  int fails  = 0;
  logic [VEC_W-1:0] expQ[$];
  string            tagQ[$];

  always #10 clk = ~clk; // 50 MHz

  fp_round_unit #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IN_W(IN_W), .EXT_W(EXT_W)) u_fp_round_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rndMode(rndMode),
    .inSign(inSign), .inExp(inExp), .inSig(inSig),
    .inNan(inNan), .inInf(inInf), .inZero(inZero),
    .outValid(outValid), .outSign(outSign), .outExp(outExp), .outSig(outSig),
    .outNan(outNan), .outInf(outInf), .outZero(outZero)
  );

  // Rational reference: compare the dropped remainder with half an ulp
  function automatic logic [VEC_W-1:0] refRound(logic s, int e, logic [IN_W-1:0] sg,
                                                 int md, logic n, logic i, logic z);
    longint kept, rem, half;
    int sh, ee, drop;
    logic up, toInf;
    if (n) return {s, 7'd0, 11'd0, 3'b100};
    if (i) return {s, 7'd0, 11'd0, 3'b010};
    if (z) return {s, 7'd0, 11'd0, 3'b001};
    sh   = (e < EMIN) ? (EMIN - e) : 0;
    ee   = (e < EMIN) ? EMIN : e;
    drop = IN_W - P + sh;
    if (drop > 40) drop = 40;
    kept = longint'(sg) >> drop;
    rem  = longint'(sg) - (kept << drop);
    half = longint'(1) << (drop - 1);
    case (md)
      1: up = (rem >= half);
      2: up = !s && (rem != 0);
      3: up = s && (rem != 0);
      4: up = 1'b0;
      default: up = (rem > half) || (rem == half && kept[0]);
    endcase
    kept = kept + longint'(up);
    if (kept == (longint'(1) << P)) begin
      kept = longint'(1) << (P - 1);
      ee   = ee + 1;
    end
    if (ee > EMAX) begin
      toInf = (md == 2) ? !s : (md == 3) ? s : (md == 4) ? 1'b0 : 1'b1;
      if (toInf) return {s, 7'd0, 11'd0, 3'b010};
      return {s, 7'(EMAX), 11'h7FF, 3'b000};
    end
    if (kept == 0) return {s, 7'd0, 11'd0, 3'b001};
    return {s, 7'(ee), 11'(kept), 3'b000};
  endfunction

  function automatic logic [IN_W-1:0] mk(logic [9:0] frac, logic [12:0] low);
    return {1'b1, frac, low};
  endfunction

  task automatic drive(string tag, logic s, int e, logic [IN_W-1:0] sg, int md,
                       logic n = 1'b0, logic i = 1'b0, logic z = 1'b0);
    @(negedge clk);
    inValid = 1'b1;
    rndMode = 3'(md);
    inSign  = s;
    inExp   = 7'(e);
    inSig   = sg;
    inNan   = n;
    inInf   = i;
    inZero  = z;
    expQ.push_back(refRound(s, e, sg, md, n, i, z));
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rstN && outValid) begin
      logic [VEC_W-1:0] got, exp;
      string tag;
      checks++;
      got = {outSign, outExp, outSig, outNan, outInf, outZero};
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected result %h, expected none", got);
      end else begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: outValid %b expected 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2: exact values in all modes
    for (int m = 0; m < 5; m++) drive("R2 exact", m[0], 3, mk(10'h2A5, 13'h0), m);
    // R3: nearest-even
    drive("R3 tie even", 1'b0, 0, mk(10'h100, 13'h1000), 0);
    drive("R3 tie odd", 1'b0, 0, mk(10'h101, 13'h1000), 0);
    drive("R3 above half", 1'b1, 0, mk(10'h100, 13'h1001), 0);
    drive("R3 below half", 1'b0, 0, mk(10'h101, 13'h0FFF), 0);
    // R4: nearest-away
    drive("R4 tie away", 1'b0, 2, mk(10'h100, 13'h1000), 1);
    drive("R4 below half", 1'b1, 2, mk(10'h100, 13'h0FFF), 1);
    // R5: directed modes with only sticky bits
    drive("R5 up pos", 1'b0, 1, mk(10'h10, 13'h1), 2);
    drive("R5 up neg", 1'b1, 1, mk(10'h10, 13'h1), 2);
    drive("R5 down neg", 1'b1, 1, mk(10'h10, 13'h1), 3);
    drive("R5 down pos", 1'b0, 1, mk(10'h10, 13'h1), 3);
    drive("R5 zero", 1'b1, 1, mk(10'h10, 13'h1FFF), 4);
    idle();
    // R6: late carry
    drive("R6 carry rne", 1'b0, 4, mk(10'h3FF, 13'h1000), 0);
    drive("R6 carry up", 1'b0, -3, mk(10'h3FF, 13'h0001), 2);
    // R7: overflow
    drive("R7 ovf rne", 1'b0, 15, mk(10'h3FF, 13'h1000), 0);
    drive("R7 ovf zero", 1'b1, 16, mk(10'h0, 13'h0), 4);
    drive("R7 ovf down pos", 1'b0, 20, mk(10'h5, 13'h0), 3);
    drive("R7 ovf down neg", 1'b1, 20, mk(10'h5, 13'h0), 3);
    drive("R7 ovf up neg", 1'b1, 63, mk(10'h5, 13'h0), 2);
    drive("R7 max kept", 1'b0, 15, mk(10'h3FF, 13'h0FFF), 0);
    // R8: subnormal range
    drive("R8 sub exact", 1'b0, -15, mk(10'h0, 13'h0), 0);
    drive("R8 sub sticky shift", 1'b0, -20, mk(10'h0, 13'h1), 2);
    drive("R8 sub tie", 1'b0, -17, mk(10'h4, 13'h0), 0);
    drive("R8 sub to normal", 1'b0, -15, 24'hFFFFFF, 0);
    drive("R8 sub far", 1'b1, -24, mk(10'h3FF, 13'h1FFF), 1);
    idle();
    // R9: total underflow
    drive("R9 zero rtz", 1'b0, -40, mk(10'h0, 13'h0), 4);
    drive("R9 min up", 1'b0, -40, mk(10'h0, 13'h0), 2);
    drive("R9 zero rne", 1'b1, -25, mk(10'h0, 13'h0), 0);
    drive("R9 min down", 1'b1, -64, mk(10'h0, 13'h0), 3);
    drive("R9 nearest up", 1'b0, -25, mk(10'h0, 13'h1), 0);
    // R10: specials bypass
    drive("R10 nan", 1'b1, 60, mk(10'h3FF, 13'h1FFF), 2, 1'b1, 1'b0, 1'b0);
    drive("R10 inf", 1'b1, 0, '0, 0, 1'b0, 1'b1, 1'b0);
    drive("R10 zero", 1'b1, -64, '0, 3, 1'b0, 1'b0, 1'b1);
    drive("R10 priority", 1'b0, 0, '0, 0, 1'b1, 1'b1, 1'b1);
    drive("R10 inf over zero", 1'b0, 0, '0, 4, 1'b0, 1'b1, 1'b1);
    // R11: spare mode codes behave as nearest-even
    drive("R11 code5", 1'b0, 0, mk(10'h101, 13'h1000), 5);
    drive("R11 code6", 1'b1, 0, mk(10'h100, 13'h1000), 6);
    drive("R11 code7", 1'b0, 0, mk(10'h100, 13'h1001), 7);
    idle();
    repeat (4) @(negedge clk);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d results missing, expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule